// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block runs one conversion at a time on a four-channel general-purpose converter. A request carries a 2-bit channel number. The sequencer then drives an 8-bit image of the converter's control bits in a fixed order, which the register-bus transport (not part of this block) copies to the converter:

1. Set the enable bit.
2. Load the channel field.
3. Wait a minimum settling gap.
4. Raise the start bit.
5. Wait for a conversion-done pulse, or give up after a timeout.

When the battery-temperature channel is requested, the external thermistor bias is switched on first. It is held for a long pre-charge before enable, and it is removed when the request ends.

Every delay is a whole number of prescaled ticks. The tick is derived from a clock-frequency parameter and a tick-rate parameter. The prescaler restarts whenever a delay begins, so each delay lasts exactly its tick count times the divide ratio.

The block also outputs the byte address of the selected channel's result word. The result word is a 16-bit value whose first byte is the high byte. On completion the low 10 bits are captured, and the control bits are returned to idle.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset `ctrlBits` is 0, `busy` is 0, `result` is 0, and `donePulse` and `timeoutErr` are 0.
- R2: The control-bit positions are as follows: start is bit 0, the channel field is bits 2:1, enable is bit 5, and thermistor bias is bit 6; bits 7, 4 and 3 stay 0. `dataAddr` equals DATA_BASE (0x54) plus twice the accepted channel.
- R3: Enable rises in an earlier update than start, and the two never rise on the same clock edge. Start rises no sooner than GAP_TICKS*TICK_DIV cycles after enable. When start rises, the channel field holds the requested channel.
- R4: For channel 2 only, bias rises at least BIAS_TICKS*TICK_DIV cycles before enable, and it is cleared when the request ends. For any other channel, bias never rises.
- R5: If no completion arrives, `timeoutErr` pulses exactly TMO_TICKS*TICK_DIV+1 cycles after start rose.
- R6: On completion, `result` takes bits 9:0 of `dataWord` as sampled with `convDone`. The upper 6 bits are discarded. The value is held until a later completion.
- R7: Start, enable and bias all go to 0 on the same edge that raises `donePulse` or `timeoutErr`.
- R8: A request made while `busy` is 1 is ignored. The channel, the address and the number of conversions are unchanged.
- R9: A `convDone` pulse that arrives before start has risen is ignored.
- R10: `donePulse` and `timeoutErr` each last one cycle and are never high together. While either is high, `busy` is 0.
- R11: `donePulse` rises one cycle after `convDone` is sampled high while waiting. If completion and timeout fall due on the same cycle, completion wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Conversion request strobe |
| reqChan | input | 2 | Requested channel |
| convDone | input | 1 | Conversion-complete pulse from the converter |
| dataWord | input | 16 | Result word, first byte in bits 15:8 |
| ctrlBits | output | 8 | Converter control-bit image |
| dataAddr | output | 8 | Byte address of the selected result word |
| busy | output | 1 | A request is in progress |
| donePulse | output | 1 | One-cycle completion strobe |
| timeoutErr | output | 1 | One-cycle timeout strobe |
| result | output | 10 | Captured 10-bit result |

## Verification
The assertions check the following on every cycle:
- Start never rises unless enable was already high.
- Cycle counters kept in the checker enforce the enable-to-start gap and the bias-to-enable gap.
- Start falls together with enable.
- The two end strobes last one cycle, are exclusive, and leave `busy` low.

Only the bench scenarios can show the rest:
- the captured 10-bit value;
- the exact timeout cycle;
- the handling of an early completion pulse and of a request made while busy;
- completion winning over a timeout due on the same cycle;
- bias staying off on the other channels.

The bench sweeps all four channels through each of these scenarios.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int START_BIT = 0;
  localparam int SEL_LSB   = 1;
  localparam int EN_BIT    = 5;
  localparam int BIAS_BIT  = 6;
  localparam int BIAS_CHAN = 2;

  typedef enum logic [1:0] {
    LIM_GAP  = 2'd0,
    LIM_BIAS = 2'd1,
    LIM_TMO  = 2'd2
  } limSel_e;

  typedef struct packed {
    logic    latchChan;
    logic    setBias;
    logic    setEn;
    logic    loadSel;
    logic    setStart;
    logic    clrAll;
    logic    cntClr;
    logic    capture;
    logic    okPulse;
    logic    errPulse;
    limSel_e limSel;
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqChan,
  input  logic       convDone,
  input  logic       cntDone,
  output seqStrobe_t strobe,
  output logic       busy
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_BIAS = 3'd1,
    S_SEL  = 3'd2,
    S_GAP  = 3'd3,
    S_WAIT = 3'd4
  } state_e;

  state_e state, nextState;

  always_comb begin
    strobe        = '0;
    strobe.limSel = LIM_GAP;
    nextState     = state;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.latchChan = 1'b1;
          strobe.cntClr    = 1'b1;
          if (reqChan == 2'(BIAS_CHAN)) begin
            strobe.setBias = 1'b1;
            nextState      = S_BIAS;
          end else begin
            strobe.setEn = 1'b1;
            nextState    = S_SEL;
          end
        end
      end
      S_BIAS: begin
        strobe.limSel = LIM_BIAS;
        if (cntDone) begin
          strobe.setEn = 1'b1;
          nextState    = S_SEL;
        end
      end
      S_SEL: begin
        strobe.loadSel = 1'b1;
        strobe.cntClr  = 1'b1;
        nextState      = S_GAP;
      end
      S_GAP: begin
        if (cntDone) begin
          strobe.setStart = 1'b1;
          strobe.cntClr   = 1'b1;
          nextState       = S_WAIT;
        end
      end
      S_WAIT: begin
        strobe.limSel = LIM_TMO;
        if (convDone) begin
          strobe.capture = 1'b1;
          strobe.clrAll  = 1'b1;
          strobe.okPulse = 1'b1;
          nextState      = S_IDLE;
        end else if (cntDone) begin
          strobe.clrAll   = 1'b1;
          strobe.errPulse = 1'b1;
          nextState       = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int GAP_TICKS  = 50,
  parameter int BIAS_TICKS = 35000,
  parameter int TMO_TICKS  = 5000000,
  parameter int DATA_BASE  = 'h54,
  parameter int ADDR_W     = 8,
  parameter int WORD_W     = 16,
  parameter int RES_W      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [1:0]        reqChan,
  input  logic [WORD_W-1:0] dataWord,
  output logic              cntDone,
  output logic [7:0]        ctrlBits,
  output logic [ADDR_W-1:0] dataAddr,
  output logic              donePulse,
  output logic              timeoutErr,
  output logic [RES_W-1:0]  result
);

  localparam int MAX_TICKS = (TMO_TICKS > BIAS_TICKS)
                           ? ((TMO_TICKS > GAP_TICKS) ? TMO_TICKS : GAP_TICKS)
                           : ((BIAS_TICKS > GAP_TICKS) ? BIAS_TICKS : GAP_TICKS);
  localparam int CW = $clog2(MAX_TICKS + 1);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0]     preCnt;
  logic              tick;
  logic [CW-1:0]     tickCnt;
  logic [CW-1:0]     limit;
  logic [1:0]        chanQ;
  logic              unusedHi;

  assign unusedHi = ^dataWord[WORD_W-1:RES_W];

  always_comb begin
    unique case (strobe.limSel)
      LIM_BIAS: limit = CW'(BIAS_TICKS);
      LIM_TMO:  limit = CW'(TMO_TICKS);
      default:  limit = CW'(GAP_TICKS);
    endcase
  end

  assign tick    = (preCnt == PW'(TICK_DIV - 1));
  assign cntDone = (tickCnt >= limit);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClr) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick && !cntDone) tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ      <= '0;
      ctrlBits   <= '0;
      result     <= '0;
      donePulse  <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      donePulse  <= strobe.okPulse;
      timeoutErr <= strobe.errPulse;
      if (strobe.latchChan) chanQ <= reqChan;
      if (strobe.setBias)   ctrlBits[BIAS_BIT] <= 1'b1;
      if (strobe.setEn)     ctrlBits[EN_BIT] <= 1'b1;
      if (strobe.loadSel)   ctrlBits[SEL_LSB +: 2] <= chanQ;
      if (strobe.setStart)  ctrlBits[START_BIT] <= 1'b1;
      if (strobe.clrAll) begin
        ctrlBits[START_BIT] <= 1'b0;
        ctrlBits[EN_BIT]    <= 1'b0;
        ctrlBits[BIAS_BIT]  <= 1'b0;
      end
      if (strobe.capture) result <= dataWord[RES_W-1:0];
    end
  end

  assign dataAddr = ADDR_W'(DATA_BASE) + ADDR_W'({chanQ, 1'b0});

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TICK_HZ    = 1_000_000,
  parameter int GAP_TICKS  = 50,
  parameter int BIAS_TICKS = 35_000,
  parameter int TMO_TICKS  = 5_000_000,
  parameter int DATA_BASE  = 'h54
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqChan,
  input  logic        convDone,
  input  logic [15:0] dataWord,
  output logic [7:0]  ctrlBits,
  output logic [7:0]  dataAddr,
  output logic        busy,
  output logic        donePulse,
  output logic        timeoutErr,
  output logic [9:0]  result
);

  localparam int TICK_DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  seqStrobe_t strobe;
  logic       cntDone;

  adc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqChan  (reqChan),
    .convDone (convDone),
    .cntDone  (cntDone),
    .strobe   (strobe),
    .busy     (busy)
  );

  adc_seq_dpath #(
    .TICK_DIV   (TICK_DIV),
    .GAP_TICKS  (GAP_TICKS),
    .BIAS_TICKS (BIAS_TICKS),
    .TMO_TICKS  (TMO_TICKS),
    .DATA_BASE  (DATA_BASE),
    .ADDR_W     (8),
    .WORD_W     (16),
    .RES_W      (10)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqChan    (reqChan),
    .dataWord   (dataWord),
    .cntDone    (cntDone),
    .ctrlBits   (ctrlBits),
    .dataAddr   (dataAddr),
    .donePulse  (donePulse),
    .timeoutErr (timeoutErr),
    .result     (result)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int TICK_DIV   = 100,
  parameter int GAP_TICKS  = 50,
  parameter int BIAS_TICKS = 35000
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ctrlBits,
  input logic       busy,
  input logic       donePulse,
  input logic       timeoutErr
);

  logic [31:0] enAge;
  logic [31:0] biasAge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enAge   <= '0;
      biasAge <= '0;
    end else begin
      enAge   <= !ctrlBits[5] ? '0 : (enAge == 32'hFFFF_FFFF ? enAge : enAge + 1);
      biasAge <= !ctrlBits[6] ? '0 : (biasAge == 32'hFFFF_FFFF ? biasAge : biasAge + 1);
    end
  end

  a_r3_enable_before_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlBits[0]) |-> $past(ctrlBits[5]));

  a_r3_start_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlBits[0]) |-> (enAge >= 32'(GAP_TICKS * TICK_DIV)));

  a_r4_bias_precharge: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrlBits[5]) && ctrlBits[6]) |-> (biasAge >= 32'(BIAS_TICKS * TICK_DIV)));

  a_r7_start_falls_with_enable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlBits[0]) |-> $fell(ctrlBits[5]));

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && timeoutErr));

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr);

  a_r10_idle_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse || timeoutErr) |-> !busy);

  a_r2_spare_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[7] == 1'b0) && (ctrlBits[4:3] == 2'b00));

endmodule

bind adc_conv_sequencer adc_seq_checker #(
  .TICK_DIV   (TICK_DIV),
  .GAP_TICKS  (GAP_TICKS),
  .BIAS_TICKS (BIAS_TICKS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlBits   (ctrlBits),
  .busy       (busy),
  .donePulse  (donePulse),
  .timeoutErr (timeoutErr)
);

// File: tb/adc_conv_sequencer_tb.sv
`timescale 1ns/1ps
module adc_conv_sequencer_tb;

  localparam int CLK_HZ = 8;
  localparam int TICK_HZ = 2;
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int GAP = 3;
  localparam int BIAS = 5;
  localparam int TMO = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqChan = '0;
  logic        convDone = 1'b0;
  logic [15:0] dataWord = '0;
  logic [7:0]  ctrlBits;
  logic [7:0]  dataAddr;
  logic        busy;
  logic        donePulse;
  logic        timeoutErr;
  logic [9:0]  result;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int tEn, tStart, tBias, tEnd;
  logic prevEn, prevStart, prevBias, biasSeen, sawDone, sawErr, earlyEnd;
  logic [7:0] ctrlAtStart;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_conv_sequencer #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .GAP_TICKS(GAP),
    .BIAS_TICKS(BIAS), .TMO_TICKS(TMO), .DATA_BASE('h54)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .convDone(convDone), .dataWord(dataWord), .ctrlBits(ctrlBits),
    .dataAddr(dataAddr), .busy(busy), .donePulse(donePulse),
    .timeoutErr(timeoutErr), .result(result)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (ctrlBits[5] && !prevEn) tEn = cyc;
    if (ctrlBits[0] && !prevStart) begin
      tStart = cyc;
      ctrlAtStart = ctrlBits;
    end
    if (ctrlBits[6] && !prevBias) begin
      tBias = cyc;
      biasSeen = 1'b1;
    end
    if (ctrlBits[5] && !prevEn && ctrlBits[0] && !prevStart)
      check("R3 enable and start rose together", 1, 0);
    if (donePulse) sawDone = 1'b1;
    if (timeoutErr) sawErr = 1'b1;
    if ((donePulse || timeoutErr) && tEnd < 0) tEnd = cyc;
    prevEn = ctrlBits[5];
    prevStart = ctrlBits[0];
    prevBias = ctrlBits[6];
  endtask

  // mode 0: done after dly, 1: timeout, 2: early done then done, 3: request while busy
  task automatic runReq(input int ch, input int mode, input int dly);
    logic [15:0] word;
    int guard;
    word = {6'b101101, 10'(ch * 211 + dly * 37 + mode * 5 + 3)};
    tEn = -1; tStart = -1; tBias = -1; tEnd = -1;
    biasSeen = 1'b0; sawDone = 1'b0; sawErr = 1'b0; earlyEnd = 1'b0;
    reqValid = 1'b1;
    reqChan = 2'(ch);
    step();
    reqValid = 1'b0;
    reqChan = 2'(3 - ch);
    guard = 0;
    while (tStart < 0 && guard < 500) begin
      if (mode == 2 && tEn == cyc) convDone = 1'b1;
      if (mode == 3 && tEn == cyc) begin
        reqValid = 1'b1;
        reqChan = 2'(3 - ch);
      end
      step();
      convDone = 1'b0;
      reqValid = 1'b0;
      if (sawDone || sawErr) earlyEnd = 1'b1;
      guard++;
    end
    check($sformatf("R9 no completion before start ch%0d", ch), int'(earlyEnd), 0);
    check($sformatf("R3 start gap ch%0d", ch), int'((tStart - tEn) >= GAP * DIV), 1);
    check($sformatf("R3 channel field at start ch%0d", ch), int'(ctrlAtStart[2:1]), ch);
    check($sformatf("R2 control image at start ch%0d", ch),
          int'(ctrlAtStart), 8'h21 | (ch << 1) | ((ch == 2) ? 8'h40 : 8'h00));
    check($sformatf("R2 data address ch%0d", ch), int'(dataAddr), 'h54 + 2 * ch);
    if (ch == 2)
      check("R4 bias precharge ch2", int'(biasSeen && (tEn - tBias) >= BIAS * DIV), 1);
    else
      check($sformatf("R4 no bias ch%0d", ch), int'(biasSeen), 0);

    if (mode == 1) begin
      while (tEnd < 0 && cyc - tStart < TMO * DIV + 20) step();
      check($sformatf("R5 timeout cycle ch%0d", ch), tEnd - tStart, TMO * DIV + 1);
      check($sformatf("R5 timeout strobe ch%0d", ch), int'(sawErr && !sawDone), 1);
    end else begin
      while (cyc - tStart < dly) step();
      convDone = 1'b1;
      dataWord = word;
      step();
      convDone = 1'b0;
      dataWord = 16'hFFFF;
      check($sformatf("R11 done one cycle after convDone ch%0d", ch), int'(donePulse), 1);
      check($sformatf("R11 no error on completion ch%0d", ch), int'(timeoutErr), 0);
      check($sformatf("R6 result ch%0d", ch), int'(result), int'(word[9:0]));
    end
    check($sformatf("R7 control cleared ch%0d", ch), int'(ctrlBits[0] | ctrlBits[5] | ctrlBits[6]), 0);
    check($sformatf("R10 not busy at end ch%0d", ch), int'(busy), 0);
    step();
    check($sformatf("R10 strobes one cycle ch%0d", ch), int'(donePulse | timeoutErr), 0);
    if (mode != 1)
      check($sformatf("R6 result held ch%0d", ch), int'(result), int'(word[9:0]));
    step();
    check($sformatf("R8 no extra conversion ch%0d", ch), int'(busy | ctrlBits[5]), 0);
  endtask

  initial begin
    prevEn = 1'b0; prevStart = 1'b0; prevBias = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    check("R1 reset ctrlBits", int'(ctrlBits), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset result", int'(result), 0);
    check("R1 reset strobes", int'(donePulse | timeoutErr), 0);
    for (int ch = 0; ch < 4; ch++) begin
      for (int d = 0; d < 3; d++) runReq(ch, 0, d * 7);
      runReq(ch, 1, 0);
      runReq(ch, 2, 2);
      runReq(ch, 3, 1);
      runReq(ch, 0, TMO * DIV);  // R11 completion and timeout due together
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule